// File: doc/BRIEF.md
# Vectored Nested Priority Interrupt Controller

This block merges up to 32 interrupt inputs into one active-low request line to a processor core. Each input has its own 3-bit urgency, its own stored handler address, and a choice between edge and level sensing. Software configures the block over a small synchronous register bus. When the request line falls, software performs one read of the acknowledge register and gets back the handler address of the winning source.

That read is the acknowledge itself. It selects the winner and records the winner's urgency on a small hardware stack of in-service levels. It also releases the request line and clears a latched edge event. A write to the end-of-service register removes the top of the stack, so a pre-empted lower-urgency handler resumes at its own level. When the stack is empty, no level is in service and any enabled pending source may raise the request. Otherwise only a source strictly above the top-of-stack level may raise it.

Top module: `aic_ctrl`

## Requirements
- R1: After synchronous reset the request line `irq_n` is high (inactive), the enable mask reads as 0, and no level is in service.
- R2: The register at byte address 4*i (i < 32) configures source i. Bits [2:0] hold its urgency, where 7 is the most urgent and 0 the least. Bit 8 selects the trigger: 1 = edge, 0 = level. Among enabled pending sources, the highest urgency wins.
- R3: When several enabled pending sources share the top urgency, the source with the smallest index wins.
- R4: The register at byte address 0x80 + 4*i holds the handler address of source i. A read of address 0x100 returns the handler address of the source that wins at the cycle of the read, including a more urgent source that arrived after the request line fell. The read data appears on `bus_rdata` one clock after the read strobe.
- R5: A read of 0x100 that finds a winner sets `irq_n` high. For an edge-triggered winner, the same read clears its latched event. A level-triggered source stays pending while its input is high.
- R6: A read of 0x100 that finds a winner pushes the winner's urgency onto the in-service stack, which makes it the current level. Afterwards `irq_n` falls only when an enabled pending source is strictly more urgent than the current level.
- R7: A write of any value to 0x110 pops the in-service stack and restores the previous current level. The same write with an empty stack changes nothing.
- R8: Writing 1s to 0x108 sets mask bits and writing 1s to 0x10C clears them. Zero bits leave a mask bit unchanged. The mask reads back at 0x104.
- R9: A source whose mask bit is clear takes no part in arbitration, so it neither raises `irq_n` nor wins a read. An edge event it latched while disabled is served once it is enabled again.
- R10: A read of 0x100 when no enabled pending source beats the current level returns the spurious address held at 0x114 (read/write) and leaves the stack unchanged.
- R11: An edge-triggered source latches a rising edge, seen after a two-flop synchroniser, and holds it until acknowledged, even after its input falls. A level-triggered source is pending exactly while its synchronised input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 10 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; a read at 0x100 also acknowledges |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| src_in | input | 32 | Raw interrupt source inputs |
| irq_n | output | 1 | Active-low interrupt request to the core |

## Verification
The assertions assume that no bus read and bus write happen in the same cycle. They also assume that no new, more urgent source becomes pending in the exact cycle of an acknowledge read, because the request would then fall again at once and the release property would not hold. The stimulus drives at most one bus operation at a time, separated by an idle cycle. It changes source inputs only while the bus is idle and lets several cycles pass for the synchroniser before any acknowledge. All nesting runs climb in strictly increasing urgency, so the stack never holds more entries than there are levels.

// File: rtl/aic_pkg.sv
package aic_pkg;

    localparam int PRIO_W     = 3;
    localparam int NUM_LEVELS = 1 << PRIO_W;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 10;
    localparam int EDGE_BIT   = 8;

    // Control register byte addresses
    localparam logic [ADDR_W-1:0] OFS_VEC_RD = 10'h100;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 10'h104;
    localparam logic [ADDR_W-1:0] OFS_ENA    = 10'h108;
    localparam logic [ADDR_W-1:0] OFS_DIS    = 10'h10C;
    localparam logic [ADDR_W-1:0] OFS_EOI    = 10'h110;
    localparam logic [ADDR_W-1:0] OFS_SPUR   = 10'h114;

    typedef struct packed {
        logic              edge_mode;
        logic [PRIO_W-1:0] prio;
    } src_cfg_t;

    typedef enum logic [1:0] {
        RGN_NONE,
        RGN_CFG,
        RGN_VEC,
        RGN_CTL
    } region_e;

    function automatic region_e decode_region(input logic [ADDR_W-1:0] a);
        case (a[ADDR_W-1:7])
            3'b000:  return RGN_CFG;
            3'b001:  return RGN_VEC;
            3'b010:  return RGN_CTL;
            default: return RGN_NONE;
        endcase
    endfunction

endpackage

// File: rtl/aic_src_front.sv
module aic_src_front (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic edge_mode,
    input  logic clr,
    output logic pend
);
    logic sync1, sync2, prev, held;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            prev  <= 1'b0;
            held  <= 1'b0;
        end else begin
            sync1 <= raw;
            sync2 <= sync1;
            prev  <= sync2;
            if (!edge_mode)
                held <= 1'b0;
            else if (sync2 && !prev)
                held <= 1'b1;
            else if (clr)
                held <= 1'b0;
        end
    end

    assign pend = edge_mode ? held : sync2;

endmodule

// File: rtl/aic_arbiter.sv
module aic_arbiter #(
    parameter int N     = 32,
    parameter int PW    = 3,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]         req,
    input  logic [N-1:0][PW-1:0] prios,
    output logic                 any,
    output logic [IDX_W-1:0]     win_idx,
    output logic [PW-1:0]        win_prio
);
    // Scan from the top index down; ">=" lets a lower index take a tie.
    always_comb begin
        any      = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i] && (!any || prios[i] >= win_prio)) begin
                any      = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = prios[i];
            end
        end
    end

endmodule

// File: rtl/aic_level_stack.sv
module aic_level_stack #(
    parameter int DEPTH = 8,
    parameter int PW    = 3,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [PW-1:0]    push_level,
    input  logic             pop,
    output logic             cur_valid,
    output logic [PW-1:0]    cur_level,
    output logic [CNT_W-1:0] depth
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PW-1:0]    mem [DEPTH];
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] top_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push && count < CNT_W'(DEPTH)) begin
            mem[count[PTR_W-1:0]] <= push_level;
            count <= count + 1'b1;
        end else if (pop && count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign top_ptr   = count - 1'b1;
    assign cur_valid = (count != '0);
    assign cur_level = mem[top_ptr[PTR_W-1:0]];
    assign depth     = count;

endmodule

// File: rtl/aic_ctrl.sv
module aic_ctrl
    import aic_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int STACK_DEPTH = NUM_LEVELS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_SRC-1:0] src_in,
    output logic              irq_n
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int CNT_W = $clog2(STACK_DEPTH + 1);

    src_cfg_t                    cfg [NUM_SRC];
    logic [DATA_W-1:0]           vec [NUM_SRC];
    logic [NUM_SRC-1:0]          mask_q;
    logic [DATA_W-1:0]           spur_q;

    logic [NUM_SRC-1:0]          pend, clr, req;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prios;
    logic                        any;
    logic [IDX_W-1:0]            win_idx;
    logic [PRIO_W-1:0]           win_prio;
    logic                        cur_valid;
    logic [PRIO_W-1:0]           cur_level;
    logic [CNT_W-1:0]            stk_depth;
    logic                        beat, ack, ack_take, eoi;

    region_e                     region;
    logic [IDX_W-1:0]            slot_idx;
    logic                        slot_ok;
    logic [DATA_W-1:0]           rd_next;

    assign region   = decode_region(bus_addr);
    assign slot_idx = IDX_W'(bus_addr[6:2]);
    assign slot_ok  = (32'(bus_addr[6:2]) < NUM_SRC);

    // Per-source front ends
    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            aic_src_front u_front (
                .clk       (clk),
                .rst       (rst),
                .raw       (src_in[g]),
                .edge_mode (cfg[g].edge_mode),
                .clr       (clr[g]),
                .pend      (pend[g])
            );
            assign prios[g] = cfg[g].prio;
            assign clr[g]   = ack_take && (win_idx == IDX_W'(g));
        end
    endgenerate

    assign req = pend & mask_q;

    aic_arbiter #(.N(NUM_SRC), .PW(PRIO_W), .IDX_W(IDX_W)) u_arb (
        .req      (req),
        .prios    (prios),
        .any      (any),
        .win_idx  (win_idx),
        .win_prio (win_prio)
    );

    assign beat     = any && (!cur_valid || win_prio > cur_level);
    assign ack      = bus_rd && (bus_addr == OFS_VEC_RD);
    assign ack_take = ack && beat;
    assign eoi      = bus_wr && (bus_addr == OFS_EOI);

    aic_level_stack #(.DEPTH(STACK_DEPTH), .PW(PRIO_W), .CNT_W(CNT_W)) u_stack (
        .clk        (clk),
        .rst        (rst),
        .push       (ack_take),
        .push_level (win_prio),
        .pop        (eoi),
        .cur_valid  (cur_valid),
        .cur_level  (cur_level),
        .depth      (stk_depth)
    );

    assign irq_n = !beat;

    // Configuration and command registers
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                cfg[i] <= '0;
                vec[i] <= '0;
            end
            mask_q <= '0;
            spur_q <= '0;
        end else if (bus_wr) begin
            case (region)
                RGN_CFG: if (slot_ok) begin
                    cfg[slot_idx].prio      <= bus_wdata[PRIO_W-1:0];
                    cfg[slot_idx].edge_mode <= bus_wdata[EDGE_BIT];
                end
                RGN_VEC: if (slot_ok) vec[slot_idx] <= bus_wdata;
                RGN_CTL: begin
                    if (bus_addr == OFS_ENA)  mask_q <= mask_q | bus_wdata[NUM_SRC-1:0];
                    if (bus_addr == OFS_DIS)  mask_q <= mask_q & ~bus_wdata[NUM_SRC-1:0];
                    if (bus_addr == OFS_SPUR) spur_q <= bus_wdata;
                end
                default: ;
            endcase
        end
    end

    // Read path
    always_comb begin
        rd_next = '0;
        case (region)
            RGN_CFG: if (slot_ok) begin
                rd_next[PRIO_W-1:0] = cfg[slot_idx].prio;
                rd_next[EDGE_BIT]   = cfg[slot_idx].edge_mode;
            end
            RGN_VEC: if (slot_ok) rd_next = vec[slot_idx];
            RGN_CTL: begin
                if (bus_addr == OFS_VEC_RD)    rd_next = beat ? vec[win_idx] : spur_q;
                else if (bus_addr == OFS_MASK) rd_next = DATA_W'(mask_q);
                else if (bus_addr == OFS_SPUR) rd_next = spur_q;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

endmodule

// File: rtl/aic_ctrl_chk.sv
module aic_ctrl_chk
    import aic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DEPTH   = 8,
    parameter int CNT_W   = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               irq_n,
    input logic [NUM_SRC-1:0] mask,
    input logic [CNT_W-1:0]   depth,
    input logic               beat
);
    logic rd_vec, wr_eoi, wr_ena, wr_dis;
    assign rd_vec = bus_rd && (bus_addr == OFS_VEC_RD);
    assign wr_eoi = bus_wr && (bus_addr == OFS_EOI);
    assign wr_ena = bus_wr && (bus_addr == OFS_ENA);
    assign wr_dis = bus_wr && (bus_addr == OFS_DIS);

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> irq_n);

    a_r5_ack_releases_line: assert property (@(posedge clk) disable iff (rst)
        (rd_vec && !irq_n) |=> irq_n);

    a_r6_ack_pushes_level: assert property (@(posedge clk) disable iff (rst)
        (rd_vec && beat) |=> depth == $past(depth) + 1'b1);

    a_r6_depth_in_range: assert property (@(posedge clk) disable iff (rst)
        depth <= CNT_W'(DEPTH));

    a_r10_spurious_keeps_stack: assert property (@(posedge clk) disable iff (rst)
        (rd_vec && !beat) |=> $stable(depth));

    a_r7_eoi_pops: assert property (@(posedge clk) disable iff (rst)
        (wr_eoi && depth != '0) |=> depth == $past(depth) - 1'b1);

    a_r7_eoi_empty_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_eoi && depth == '0) |=> depth == '0);

    a_r8_enable_sets: assert property (@(posedge clk) disable iff (rst)
        wr_ena |=> (mask & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0]));

    a_r8_disable_clears: assert property (@(posedge clk) disable iff (rst)
        wr_dis |=> (mask & $past(bus_wdata[NUM_SRC-1:0])) == '0);

endmodule

bind aic_ctrl aic_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .DEPTH   (STACK_DEPTH),
    .CNT_W   (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .irq_n     (irq_n),
    .mask      (mask_q),
    .depth     (stk_depth),
    .beat      (beat)
);

// File: tb/tb_aic_ctrl.sv
module tb_aic_ctrl;
    localparam logic [9:0] A_ACK = 10'h100, A_MASK = 10'h104, A_ENA = 10'h108,
                           A_DIS = 10'h10C, A_EOI = 10'h110, A_SPUR = 10'h114;
    localparam logic [31:0] SPUR = 32'hDEAD_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_in = '0;
    logic        irq_n;

    int checks = 0, errors = 0;
    logic did_rd = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    aic_ctrl dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .src_in(src_in), .irq_n(irq_n)
    );

    // Monitor: compare each completed read against the scoreboard queue
    always @(posedge clk) did_rd <= bus_rd;
    always @(negedge clk) begin
        if (did_rd && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s read actual %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [9:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string t);
        @(negedge clk);
        checks++;
        if (irq_n !== e) begin
            errors++;
            $display("FAIL %s irq_n actual %b expected %b", t, irq_n, e);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input int s);
        @(negedge clk);
        src_in[s] = 1'b1;
        idle(3);
        src_in[s] = 1'b0;
        idle(4);
    endtask

    task automatic set_level(input int s, input logic v);
        @(negedge clk);
        src_in[s] = v;
        idle(4);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        check_irq(1'b1, "R1 reset");
        bus_read(A_MASK, 32'h0, "R1 mask after reset");

        // Configuration: src3 level prio2, src5 edge prio2, src10 edge prio6
        bus_write(10'h00C, 32'h0000_0002);
        bus_write(10'h014, 32'h0000_0102);
        bus_write(10'h028, 32'h0000_0106);
        bus_write(10'h08C, 32'h300);
        bus_write(10'h094, 32'h500);
        bus_write(10'h0A8, 32'hA00);
        bus_write(A_SPUR, SPUR);
        bus_read(10'h014, 32'h0000_0102, "R2 config readback");

        bus_write(A_ENA, 32'h0000_0428);
        bus_read(A_MASK, 32'h0000_0428, "R8 enable");
        bus_write(A_DIS, 32'h0000_0020);
        bus_read(A_MASK, 32'h0000_0408, "R8 disable");
        bus_write(A_ENA, 32'h0000_0020);
        bus_write(A_DIS, 32'h0);
        bus_read(A_MASK, 32'h0000_0428, "R8 zero write keeps");

        bus_read(A_ACK, SPUR, "R10 idle spurious");
        check_irq(1'b1, "R10 idle line");

        // Tie at prio 2 between src3 (level) and src5 (edge)
        pulse(5);
        set_level(3, 1'b1);
        check_irq(1'b0, "R11 pending raises line");
        bus_read(A_ACK, 32'h300, "R3 tie lowest index");
        check_irq(1'b1, "R5 ack releases line");
        idle(3);
        check_irq(1'b1, "R6 equal level no reassert");

        // Nesting: src10 prio 6
        pulse(10);
        check_irq(1'b0, "R6 higher level reasserts");
        bus_read(A_ACK, 32'hA00, "R2 higher urgency wins");
        check_irq(1'b1, "R5 nested ack releases");
        bus_read(A_ACK, SPUR, "R10 nothing beats level 6");
        bus_write(A_EOI, 32'h0);
        check_irq(1'b1, "R7 pop to level 2");
        bus_write(A_EOI, 32'h0);
        check_irq(1'b0, "R7 empty stack any level");
        bus_read(A_ACK, 32'h300, "R5 level source stays pending");
        set_level(3, 1'b0);
        bus_write(A_EOI, 32'h0);
        check_irq(1'b0, "R11 edge event held");
        bus_read(A_ACK, 32'h500, "R11 edge source served");
        bus_write(A_EOI, 32'h0);
        check_irq(1'b1, "R5 edge cleared by ack");
        bus_read(A_ACK, SPUR, "R5 nothing left");

        // Empty-stack EOI ignored
        bus_write(A_EOI, 32'h0);
        bus_write(A_EOI, 32'h0);
        set_level(3, 1'b1);
        check_irq(1'b0, "R7 after empty eoi");
        bus_read(A_ACK, 32'h300, "R7 after empty eoi vector");
        check_irq(1'b1, "R7 level 2 in service");
        bus_write(A_EOI, 32'h0);

        // Newer, more urgent source before the read
        check_irq(1'b0, "R4 line low for src3");
        pulse(10);
        bus_read(A_ACK, 32'hA00, "R4 newer higher vector");
        check_irq(1'b1, "R4 released");
        bus_write(A_EOI, 32'h0);
        bus_read(A_ACK, 32'h300, "R4 lower follows");

        // Disabled source ignored
        bus_write(A_DIS, 32'h0000_0400);
        pulse(10);
        check_irq(1'b1, "R9 disabled no request");
        bus_write(A_EOI, 32'h0);
        bus_read(A_ACK, 32'h300, "R9 disabled does not win");
        bus_write(A_ENA, 32'h0000_0400);
        check_irq(1'b0, "R9 re-enabled latched event");
        bus_read(A_ACK, 32'hA00, "R9 re-enabled vector");
        bus_write(A_EOI, 32'h0);
        bus_write(A_EOI, 32'h0);
        set_level(3, 1'b0);
        check_irq(1'b1, "R11 level follows input");

        idle(3);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule